// File: doc/BRIEF.md
# Digital Second-Order Delta-Sigma Modulator

This block turns a stream of signed multi-bit samples into a one-bit stream whose low-frequency content follows the input. The quantization error is pushed towards high frequencies by two cascaded accumulators. On every cycle with the sample enable high, the block takes one input word. It updates both integrators from the current output decision and then decides the next output bit. A downstream decimator, which lies outside this block, recovers the signal by low-pass filtering the bit stream or its ±full-scale equivalent. The design targets oversampling ratios of 8 to 512. Under the linearized model its noise transfer is second order, about 15 dB less in-band noise for each doubling of the ratio.

The feedback level FS is 2^(DW-2), half the positive input span. Inputs well inside ±FS keep the loop stable. Inputs beyond ±FS drive the integrators into their saturation limits, and the overload flag reports this. The loop coefficients are fixed scalings. The input and the first-stage feedback each enter with weight 1/4. The first integrator feeds the second with weight 1/4. The second-stage feedback has weight 1/6. The integrators carry FRAC fraction bits so that the 1/4 scalings lose nothing, and GUARD extra integer bits give headroom.

The quantizer is a two-state machine. In state NEG the output bit is 0, and the machine moves to POS when the next second-integrator value exceeds the threshold +T. In state POS the output bit is 1, and the machine returns to NEG when that value falls below −T. In all other cases it stays in its current state. T is the hysteresis input, limited to a tenth of the 2·FS feedback span.

Top module: `sdm2_mod`

## Requirements
- R1: While rst is high at a clock edge, both integrators clear, the quantizer enters NEG, and the overload flag clears. After that edge, bit_out=0, lvl_out=−FS and ovl=0.
- R2: lvl_out always equals +FS (16384 at DW=16) when bit_out=1 and −FS when bit_out=0.
- R3: With en low, the integrators, quantizer state and overload flag all hold, and din has no effect. bit_out, lvl_out and ovl stay unchanged.
- R4: With a DC input |din| ≤ 0.75·FS, the mean of lvl_out over 2048 enabled samples after a 64-sample settle lies within 400 counts of din. This holds for en high on every cycle and for en high on every second cycle.
- R5: Each enabled update works as follows, with v the current bit as ±FS. x1 gains (din − v)/4. x2 gains x1/4 − v/6, using the x1 value from before the update. Both are held in units of 2^-FRAC. Starting from reset with hysteresis 0, the first enabled sample therefore sets bit_out to 1 for any din.
- R6: With hysteresis 3000, a run from reset with din=0 keeps bit_out at 0 after the first enabled sample. bit_out becomes 1 after the second enabled sample, because x2 first reaches 43690 and then 103764 in units of 1/16, against a threshold of 48000.
- R7: A hysteresis value above FS/5 (3276 at DW=16) acts as FS/5. So hysteresis 20000 gives the same first two bits as R6: 0, then 1.
- R8: The integrators saturate at the limits of their W-bit range and never wrap. ovl is registered on each enabled sample and is 1 exactly when an integrator reached a limit in that update. With din=32767, ovl rises within 400 enabled samples. During the DC runs of R4 it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; the state advances only when high |
| din | input | DW | Signed input sample |
| hyst | input | DW | Quantizer hysteresis in input units, clamped to FS/5 |
| bit_out | output | 1 | Modulator output bit |
| lvl_out | output | DW | Signed feedback level, ±FS, selected by bit_out |
| ovl | output | 1 | An integrator hit its saturation limit on the last enabled sample |

## Verification
A wrong coefficient or fraction alignment changes the exact x2 values just after reset. This shows up within the first two enabled samples, when bit_out goes to 1 too early or too late, for both the plain threshold and the clamped hysteresis threshold. A sign or scaling error in either feedback path drifts the running mean of lvl_out away from the DC input, and this becomes clear within a couple of thousand samples. An integrator that wraps instead of saturating flips sign at full scale. That breaks the no-wrap property in the cycle it happens, and the overload flag then fails to rise under an out-of-range input. State that moves while en is low appears on the very next edge as a change in bit_out or ovl.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;

    // Quantizer decision states: the output bit equals the state encoding.
    typedef enum logic {
        Q_NEG = 1'b0,
        Q_POS = 1'b1
    } qstate_e;

endpackage

// File: rtl/sdm2_integ.sv
// Saturating accumulator stage of the modulator loop.
module sdm2_integ #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] delta,
    output logic signed [W-1:0] acc,
    output logic signed [W-1:0] acc_nxt,
    output logic                sat_hit
);

    localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] sum;

    always_comb begin
        sum = {acc[W-1], acc} + {delta[W-1], delta};
        if (sum > MAXV) begin
            acc_nxt = MAXV[W-1:0];
        end else if (sum < MINV) begin
            acc_nxt = MINV[W-1:0];
        end else begin
            acc_nxt = sum[W-1:0];
        end
        sat_hit = (sum >= MAXV) || (sum <= MINV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc_nxt;
        end
    end

endmodule

// File: rtl/sdm2_quant.sv
// Single-comparator quantizer with symmetric hysteresis, as a two-state machine.
module sdm2_quant
    import sdm2_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] x_nxt,
    input  logic signed [W-1:0] thr,
    output logic                bit_q
);

    qstate_e st;
    qstate_e st_nxt;

    // Transitions: NEG->POS when x_nxt > +thr, POS->NEG when x_nxt < -thr.
    always_comb begin
        st_nxt = st;
        unique case (st)
            Q_NEG: if (x_nxt > thr)  st_nxt = Q_POS;
            Q_POS: if (x_nxt < -thr) st_nxt = Q_NEG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= Q_NEG;
        end else if (en) begin
            st <= st_nxt;
        end
    end

    always_comb begin
        bit_q = (st == Q_POS);
    end

endmodule

// File: rtl/sdm2_mod.sv
// Second-order one-bit delta-sigma modulator with fixed fractional coefficients.
module sdm2_mod
    import sdm2_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 4,
    parameter int FRAC  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] din,
    input  logic [DW-1:0]        hyst,
    output logic                 bit_out,
    output logic signed [DW-1:0] lvl_out,
    output logic                 ovl
);

    localparam int W    = DW + GUARD + FRAC;
    localparam int NSTG = 2;
    localparam int FS   = 1 << (DW - 2);
    localparam int HMAX = (2 * FS) / 10;
    localparam int FB2  = (FS << FRAC) / 6;

    localparam logic signed [DW+1:0] FS_E   = (DW+2)'(FS);
    localparam logic signed [DW-1:0] FS_D   = DW'(FS);
    localparam logic signed [W-1:0]  FB2_W  = W'(FB2);
    localparam logic [DW-1:0]        HMAX_U = DW'(HMAX);

    logic signed [W-1:0]  x_q [NSTG];
    logic signed [W-1:0]  x_n [NSTG];
    logic signed [W-1:0]  dlt [NSTG];
    logic [NSTG-1:0]      sat;
    logic signed [W-1:0]  x1_q;
    logic signed [W-1:0]  x2_q;
    logic signed [DW+1:0] din_e;
    logic signed [DW+1:0] fb_e;
    logic signed [DW+1:0] err1;
    logic [DW-1:0]        hc;
    logic signed [W-1:0]  thr;

    assign x1_q = x_q[0];
    assign x2_q = x_q[1];

    // Loop increments: stage one by (u - v)/4, stage two by x1/4 - v/6.
    always_comb begin
        din_e  = {{2{din[DW-1]}}, din};
        fb_e   = bit_out ? FS_E : -FS_E;
        err1   = din_e - fb_e;
        dlt[0] = {{(W-DW-2){err1[DW+1]}}, err1} <<< (FRAC - 2);
        dlt[1] = (x_q[0] >>> 2) + (bit_out ? -FB2_W : FB2_W);
    end

    // Hysteresis clamped to a tenth of the feedback span, aligned to state units.
    always_comb begin
        hc  = (hyst > HMAX_U) ? HMAX_U : hyst;
        thr = {{(W-DW){1'b0}}, hc} <<< FRAC;
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        sdm2_integ #(.W(W)) u_int (
            .clk     (clk),
            .rst     (rst),
            .en      (en),
            .delta   (dlt[k]),
            .acc     (x_q[k]),
            .acc_nxt (x_n[k]),
            .sat_hit (sat[k])
        );
    end

    sdm2_quant #(.W(W)) u_quant (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .x_nxt (x_n[NSTG-1]),
        .thr   (thr),
        .bit_q (bit_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovl <= 1'b0;
        end else if (en) begin
            ovl <= |sat;
        end
    end

    always_comb begin
        lvl_out = bit_out ? FS_D : -FS_D;
    end

endmodule

// File: rtl/sdm2_mod_chk.sv
// Property checker for sdm2_mod, attached by bind.
module sdm2_mod_chk #(
    parameter int DW = 16,
    parameter int W  = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 bit_out,
    input logic signed [DW-1:0] lvl_out,
    input logic                 ovl,
    input logic signed [W-1:0]  x1,
    input logic signed [W-1:0]  x2
);

    localparam logic signed [DW-1:0] FS_D = DW'(1 << (DW - 2));
    localparam logic signed [W-1:0]  HALF = W'(1 << (W - 2));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!bit_out && !ovl && x1 == '0 && x2 == '0));

    p_level_r2: assert property (@(posedge clk) disable iff (rst)
        lvl_out == (bit_out ? FS_D : -FS_D));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bit_out) && $stable(ovl) && $stable(x1) && $stable(x2)));

    p_no_wrap_x1_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(x1) >= HALF) |-> (x1 > 0));

    p_no_wrap_x2_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(x2) >= HALF) |-> (x2 > 0));

    p_no_wrap_neg_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(x1) <= -HALF) |-> (x1 < 0));

endmodule

bind sdm2_mod sdm2_mod_chk #(.DW(DW), .W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bit_out (bit_out),
    .lvl_out (lvl_out),
    .ovl     (ovl),
    .x1      (x1_q),
    .x2      (x2_q)
);

// File: tb/sdm2_mod_test.sv
module sdm2_mod_test;

    localparam int DW  = 16;
    localparam int FS  = 1 << (DW - 2);
    localparam int NV  = 6;
    localparam int TOL = 400;

    localparam int VDIN [NV] = '{0, 8192, -8192, 12000, -4000, 2500};
    localparam int VHYS [NV] = '{0, 0, 3000, 0, 3276, 1000};
    localparam int VGAP [NV] = '{0, 1, 0, 0, 1, 0};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en  = 1'b0;
    logic signed [DW-1:0] din = '0;
    logic [DW-1:0]        hyst = '0;
    logic                 bit_out;
    logic signed [DW-1:0] lvl_out;
    logic                 ovl;

    int checks = 0;
    int errors = 0;

    sdm2_mod #(.DW(DW)) uut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .din     (din),
        .hyst    (hyst),
        .bit_out (bit_out),
        .lvl_out (lvl_out),
        .ovl     (ovl)
    );

    always #2.5 clk = ~clk;

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // One enabled sample, optionally preceded by an idle cycle.
    task automatic sample(input int gap);
        if (gap != 0) begin
            en = 1'b0;
            tick();
        end
        en = 1'b1;
        tick();
        en = 1'b0;
    endtask

    logic [DW-1:0] cap_bit;
    logic signed [DW-1:0] cap_lvl;
    logic cap_ovl;
    bit seen_ovl;

    initial begin
        // R1: reset state
        do_reset();
        chk(bit_out == 1'b0, "R1 bit_out after reset", longint'(bit_out), 0);
        chk(lvl_out == -FS, "R1 lvl_out after reset", longint'(lvl_out), -FS);
        chk(ovl == 1'b0, "R1 ovl after reset", longint'(ovl), 0);

        // R4, R2, R8, R3: DC vector table
        for (int v = 0; v < NV; v++) begin
            longint sum;
            longint mean;
            bit lvl_ok;
            do_reset();
            din  = 16'(VDIN[v]);
            hyst = 16'(VHYS[v]);
            for (int n = 0; n < 64; n++) sample(VGAP[v]);
            sum = 0;
            lvl_ok = 1'b1;
            for (int n = 0; n < 2048; n++) begin
                sample(VGAP[v]);
                sum += longint'(lvl_out);
                if (lvl_out != (bit_out ? 16'(FS) : -16'(FS))) lvl_ok = 1'b0;
            end
            mean = sum / 2048;
            chk((mean - VDIN[v] <= TOL) && (VDIN[v] - mean <= TOL),
                "R4 DC mean", mean, longint'(VDIN[v]));
            chk(lvl_ok, "R2 level follows bit", longint'(lvl_out),
                bit_out ? longint'(FS) : -longint'(FS));
            chk(ovl == 1'b0, "R8 no overload in stable range", longint'(ovl), 0);
        end

        // R5: first enabled sample with zero hysteresis
        do_reset();
        din  = -16'(FS);
        hyst = '0;
        sample(0);
        chk(bit_out == 1'b1, "R5 first sample decision", longint'(bit_out), 1);

        // R6: hysteresis 3000 delays the first transition by one sample
        do_reset();
        din  = '0;
        hyst = 16'd3000;
        sample(0);
        chk(bit_out == 1'b0, "R6 first sample held by hysteresis", longint'(bit_out), 0);
        sample(0);
        chk(bit_out == 1'b1, "R6 second sample crosses threshold", longint'(bit_out), 1);

        // R7: oversized hysteresis clamps to FS/5
        do_reset();
        din  = '0;
        hyst = 16'd20000;
        sample(0);
        chk(bit_out == 1'b0, "R7 clamped hysteresis first sample", longint'(bit_out), 0);
        sample(0);
        chk(bit_out == 1'b1, "R7 clamped hysteresis second sample", longint'(bit_out), 1);

        // R3: en low freezes outputs while din moves
        do_reset();
        din  = 16'd5000;
        hyst = '0;
        for (int n = 0; n < 7; n++) sample(0);
        cap_bit = {15'd0, bit_out};
        cap_lvl = lvl_out;
        cap_ovl = ovl;
        en = 1'b0;
        for (int n = 0; n < 20; n++) begin
            din = (n % 2 == 0) ? 16'sh7fff : 16'sh8000;
            tick();
        end
        chk({15'd0, bit_out} == cap_bit, "R3 bit_out held", longint'(bit_out), longint'(cap_bit));
        chk(lvl_out == cap_lvl, "R3 lvl_out held", longint'(lvl_out), longint'(cap_lvl));
        chk(ovl == cap_ovl, "R3 ovl held", longint'(ovl), longint'(cap_ovl));

        // R8: out-of-range input drives saturation and raises the flag
        do_reset();
        din  = 16'sh7fff;
        hyst = '0;
        seen_ovl = 1'b0;
        for (int n = 0; n < 400; n++) begin
            sample(0);
            if (ovl) seen_ovl = 1'b1;
        end
        chk(seen_ovl, "R8 overload flag raised", longint'(seen_ovl), 1);
        chk(bit_out == 1'b1, "R8 saturated loop holds positive", longint'(bit_out), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule